// File: doc/BRIEF.md
# Board-Select Insertion Handler

This block follows an active-low board-select line that tells a hot-swap controller whether a plug-in card is seated. The line arrives asynchronously, passes through a two-flop synchronizer, and its edges are turned into single-cycle events. Either edge raises a change-of-state pulse that a fault register can latch. When the line rises, the card has been pulled, and the block asks for every power switch to turn off at once. When the line falls, the card has been seated, and the block asks for all other fault bits to be cleared.

After a falling edge, the block waits for a fixed hold time of `HOLD_CYCLES` clocks. The default is 100 ms at 200 MHz. It then copies the ON input into its per-channel on-control bits. A sequence-mode input picks what is copied. With sequence mode clear, all channels take the ON level. With sequence mode set, only channel 0 takes the ON level, and the higher channels were already cleared at insertion so that a sequencer can bring them up one by one. If the line rises again before the hold time ends, the pending capture is dropped. The next insertion starts the sequence over.

Top module: `bdsel_insert_ctrl`

## Requirements
- R1: Each edge of the board-select line, in either direction, gives exactly one cycle of `cos_pulse`. The pulse appears three rising clock edges after the input changes: two synchronizer stages plus one output register.
- R2: `bdsel_lvl` equals the board-select input as it stood two rising clock edges earlier.
- R3: A low-to-high transition (removal) gives one cycle of `sw_off_req`, in the same cycle as its `cos_pulse`. A falling edge never raises `sw_off_req`.
- R4: A high-to-low transition (insertion) gives one cycle of `clr_faults`, in the same cycle as its `cos_pulse`. A removal never raises `clr_faults`.
- R5: On insertion with `seq_mode` = 1, on-control bits 3 down to 1 read 0 from the cycle in which `clr_faults` is high. Bit 0 keeps its value.
- R6: If the line stays low, the capture happens `HOLD_CYCLES` clock edges after the edge that raised `clr_faults`. With `seq_mode` = 0, every `onctl` bit takes the level of `on_lvl`. With `seq_mode` = 1, only `onctl[0]` takes it and bits 3..1 are left as they are. `onctl` changes at no other time.
- R7: A removal before the hold time ends cancels the capture. `onctl` then stays unchanged until a later insertion completes its own full hold.
- R8: While `rst_n` is low, and in the first cycle after it is released, `bdsel_lvl` = 1, all pulses are 0 and `onctl` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bdsel_n_async | input | 1 | Board-select line, active low, asynchronous |
| on_lvl | input | 1 | ON input level sampled at capture |
| seq_mode | input | 1 | 1 = capture into channel 0 only and clear upper channels on insertion |
| bdsel_lvl | output | 1 | Synchronized present level of board-select |
| cos_pulse | output | 1 | One-cycle change-of-state event |
| clr_faults | output | 1 | One-cycle request to clear all other fault bits |
| sw_off_req | output | 1 | One-cycle request to turn all switches off |
| onctl | output | NCH | Captured on-control bits, channel 0 at bit 0 |

## Verification
Directed cases cover four things: a full insertion in each sequence mode, the clearing of the upper channels that sequence mode causes, and a removal halfway through the hold window. Together they separate the two capture widths, and they separate a capture that was cancelled from one that was only delayed. Random segments then hold the line for anywhere from a single cycle up to twice the hold time, while the ON level changes every cycle and the sequence mode changes per segment. The very short segments stress edge detection of back-to-back transitions. The segments close to the hold length expose off-by-one errors in the capture cycle. A cycle-level reference model in the bench predicts every output, so a wrong capture level or a wrong cycle shows up as a mismatch.

// File: rtl/bdsel_pkg.sv
package bdsel_pkg;

    typedef struct packed {
        logic chg;
        logic off;
        logic clr;
        logic lvl;
    } edge_regs_t;

    typedef struct packed {
        logic active;
    } hold_flags_t;

endpackage

// File: rtl/bdsel_sync.sv
module bdsel_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LAST-1:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[LAST];

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q[1] == $past(sh_q[0]));
endmodule

// File: rtl/bdsel_edge.sv
module bdsel_edge
    import bdsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o,
    output logic chg_o,
    output logic off_o,
    output logic clr_o
);
    edge_regs_t r_d, r_q;

    always_comb begin
        rise_o  = lvl_i & ~r_q.lvl;
        fall_o  = ~lvl_i & r_q.lvl;
        r_d     = r_q;
        r_d.lvl = lvl_i;
        r_d.chg = rise_o | fall_o;
        r_d.off = rise_o;
        r_d.clr = fall_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{chg: 1'b0, off: 1'b0, clr: 1'b0, lvl: 1'b1};
        else        r_q <= r_d;
    end

    assign chg_o = r_q.chg;
    assign off_o = r_q.off;
    assign clr_o = r_q.clr;

    // R3
    off_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.off |-> r_q.lvl);

    // R4
    clr_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.clr |-> !r_q.lvl);

    // R1
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.off, r_q.clr}));
endmodule

// File: rtl/bdsel_hold_timer.sv
module bdsel_hold_timer
    import bdsel_pkg::*;
#(
    parameter int HOLD_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cancel_i,
    output logic done_o
);
    localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    hold_flags_t f_d, f_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        f_d    = f_q;
        cnt_d  = cnt_q;
        done_o = f_q.active && (cnt_q == LAST) && !cancel_i;
        if (cancel_i) begin
            f_d.active = 1'b0;
        end else if (start_i) begin
            f_d.active = 1'b1;
            cnt_d      = '0;
        end else if (done_o) begin
            f_d.active = 1'b0;
        end else if (f_q.active) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q   <= '{active: 1'b0};
            cnt_q <= '0;
        end else begin
            f_q   <= f_d;
            cnt_q <= cnt_d;
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.active |-> cnt_q <= LAST);

    // R7
    cancel_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_i |=> !f_q.active);
endmodule

// File: rtl/bdsel_insert_ctrl.sv
module bdsel_insert_ctrl #(
    parameter int NCH         = 4,
    parameter int HOLD_CYCLES = 20_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bdsel_n_async,
    input  logic           on_lvl,
    input  logic           seq_mode,
    output logic           bdsel_lvl,
    output logic           cos_pulse,
    output logic           clr_faults,
    output logic           sw_off_req,
    output logic [NCH-1:0] onctl
);
    logic lvl_s, rise, fall, done;
    logic [NCH-1:0] onctl_d, onctl_q;

    bdsel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(bdsel_n_async), .q(lvl_s)
    );

    bdsel_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_s),
        .rise_o(rise), .fall_o(fall),
        .chg_o(cos_pulse), .off_o(sw_off_req), .clr_o(clr_faults)
    );

    bdsel_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(fall), .cancel_i(rise), .done_o(done)
    );

    always_comb begin
        onctl_d = onctl_q;
        if (fall && seq_mode)
            onctl_d[NCH-1:1] = '0;
        if (done) begin
            if (seq_mode) onctl_d[0] = on_lvl;
            else          onctl_d    = {NCH{on_lvl}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) onctl_q <= '0;
        else        onctl_q <= onctl_d;
    end

    assign bdsel_lvl = lvl_s;
    assign onctl     = onctl_q;

    // R6
    onctl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(onctl_q) |-> $past(done || (fall && seq_mode)));

    // R5
    seq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_faults && $past(seq_mode)) |-> onctl_q[NCH-1:1] == '0);
endmodule

// File: tb/sim_bdsel_insert_ctrl.sv
module sim_bdsel_insert_ctrl;
    localparam int H = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bdsel_n = 1'b1;
    logic on_lvl = 1'b0;
    logic seq_mode = 1'b0;
    logic bdsel_lvl, cos_pulse, clr_faults, sw_off_req;
    logic [3:0] onctl;

    int checks = 0;
    int failures = 0;
    bit done_run = 1'b0;

    always #2.5 clk = ~clk;

    bdsel_insert_ctrl #(.NCH(4), .HOLD_CYCLES(H), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bdsel_n_async(bdsel_n), .on_lvl(on_lvl),
        .seq_mode(seq_mode), .bdsel_lvl(bdsel_lvl), .cos_pulse(cos_pulse),
        .clr_faults(clr_faults), .sw_off_req(sw_off_req), .onctl(onctl)
    );

    // reference model built from the requirements
    logic m_s1 = 1, m_s2 = 1, m_p = 1, m_chg = 0, m_off = 0, m_clr = 0, m_act = 0;
    int   m_cnt = 0;
    logic [3:0] m_on = 0;

    function automatic logic [3:0] capture(input logic [3:0] cur, input logic seq, input logic on);
        return seq ? {cur[3:1], on} : {4{on}};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_p = 1; m_chg = 0; m_off = 0; m_clr = 0;
            m_act = 0; m_cnt = 0; m_on = 0;
        end else begin
            logic rise, fall, dn;
            rise = m_s2 & ~m_p;
            fall = ~m_s2 & m_p;
            dn   = m_act && (m_cnt == H-1) && !rise;
            if (fall && seq_mode) m_on[3:1] = 3'b000;
            if (dn) m_on = capture(m_on, seq_mode, on_lvl);
            if (rise) m_act = 0;
            else if (fall) begin m_act = 1; m_cnt = 0; end
            else if (dn) m_act = 0;
            else if (m_act) m_cnt++;
            m_chg = rise | fall; m_off = rise; m_clr = fall;
            m_p = m_s2; m_s2 = m_s1; m_s1 = bdsel_n;
        end
    end

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            chk("R2 level", {3'b0, bdsel_lvl}, {3'b0, m_s2});
            chk("R1 change pulse", {3'b0, cos_pulse}, {3'b0, m_chg});
            chk("R3 switch off", {3'b0, sw_off_req}, {3'b0, m_off});
            chk("R4 clear faults", {3'b0, clr_faults}, {3'b0, m_clr});
            chk("R6 onctl", onctl, m_on);
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_4B5);
        wait_n(4);
        // R8 reset state
        chk("R8 level", {3'b0, bdsel_lvl}, 4'h1);
        chk("R8 pulses", {1'b0, cos_pulse, clr_faults, sw_off_req}, 4'h0);
        chk("R8 onctl", onctl, 4'h0);
        rst_n = 1'b1;
        wait_n(1);
        chk("R8 onctl after release", onctl, 4'h0);

        // R6 full insertion, all channels
        seq_mode = 0; on_lvl = 1; bdsel_n = 0;
        wait_n(H + 8);
        chk("R6 capture all", onctl, 4'hF);

        // R3 removal, then R5 sequence insertion
        bdsel_n = 1; wait_n(8);
        chk("R3 onctl kept on removal", onctl, 4'hF);
        seq_mode = 1; on_lvl = 0; bdsel_n = 0;
        wait_n(5);
        chk("R5 upper cleared", onctl, 4'h1);
        wait_n(H + 5);
        chk("R6 capture ch0 only", onctl, 4'h0);

        // R7 cancel during hold
        bdsel_n = 1; wait_n(8);
        seq_mode = 0; on_lvl = 1; bdsel_n = 0;
        wait_n(H / 2);
        bdsel_n = 1;
        wait_n(H + 10);
        chk("R7 capture cancelled", onctl, 4'h0);

        // random segments
        for (int s = 0; s < 300; s++) begin
            int len;
            len = 1 + int'($urandom_range(2 * H));
            seq_mode = $urandom_range(1);
            bdsel_n = ~bdsel_n;
            for (int c = 0; c < len; c++) begin
                on_lvl = $urandom_range(1);
                @(negedge clk);
            end
        end
        bdsel_n = 0; wait_n(H + 8);

        done_run = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule